// File: doc/BRIEF.md
# Multiplexed Segment LCD Waveform Generator

This block produces the drive codes for a passive segment LCD panel with four common lines and fourteen segment lines, run at 1/4 duty and 1/3 bias. A CPU stores the pixel pattern in a seven-byte display buffer through a plain write port. Each byte holds two segments across all four commons. The block divides the system clock by a fixed factor and then by a programmable prescaler. From that drive clock it steps through four common phases per frame and reverses the drive polarity on every frame, so no pixel sees a net DC voltage.

Every common and segment pin gets a 2-bit level code: 2'b00 = Vss, 2'b01 = V1, 2'b10 = V2, 2'b11 = Vcc. An external analog stage turns these codes into the panel voltages. Three group enables decide which pins the block drives.

Top module: `lcd_mux_driver`

## Requirements
- R1: After reset the frame polarity is positive, common 0 is the active common, the prescaler in use is 1 and every buffer byte reads zero. COM0 therefore shows Vcc, the other commons show V1 and every enabled segment shows V2.
- R2: A write with an address from BASE_ADDR (default 0xE1) to BASE_ADDR+6 stores wrData into buffer byte (address − BASE_ADDR). A write to any other address changes no output.
- R3: Buffer byte n controls segments 2n and 2n+1. Bit 4+c is the pixel of segment 2n on common c, and bit c is the pixel of segment 2n+1 on common c, for c = 0..3.
- R4: The active common shows Vcc under positive polarity and Vss under negative polarity. Inactive commons show V1 under positive polarity and V2 under negative polarity.
- R5: A lit segment shows the level opposite the active common: Vss under positive polarity and Vcc under negative. An unlit segment shows V2 under positive polarity and V1 under negative.
- R6: Each common phase lasts FIXED_DIV × P × PHASE_TICKS clock cycles, where P is the prescaler in use. The phases run COM0, COM1, COM2, COM3 and then repeat.
- R7: The polarity flips at the end of every frame, that is, when COM3 hands over to COM0, and at no other time.
- R8: A prescale input of 0 is used as 1.
- R9: The prescale input is sampled only at a frame boundary. A change in the middle of a frame leaves the current frame's timing untouched, and the first frame after reset runs at prescaler 1.
- R10: Enable group A gates COM0–COM3 and SEG0–SEG3. Group B gates SEG4–SEG5. Group C gates SEG6–SEG13. A pin whose group is disabled shows level 2'b00 and has its drive flag low. A pin whose group is enabled has its drive flag high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Buffer write strobe |
| wrAddr | input | ADDR_W (8) | Buffer write address |
| wrData | input | 8 | Buffer write data |
| prescale | input | PRE_W (8) | Prescaler value, sampled at each frame boundary |
| enGrpA | input | 1 | Enable for COM0–COM3 and SEG0–SEG3 |
| enGrpB | input | 1 | Enable for SEG4–SEG5 |
| enGrpC | input | 1 | Enable for SEG6–SEG13 |
| comLevel | output | 8 | 2-bit level code per common, COM c at bits 2c+1:2c |
| segLevel | output | 2×NUM_SEG (28) | 2-bit level code per segment, SEG s at bits 2s+1:2s |
| comDrive | output | 4 | Drive flag per common |
| segDrive | output | NUM_SEG (14) | Drive flag per segment |

## Verification
The bench builds the block with FIXED_DIV = 2 and PHASE_TICKS = 4. A phase then lasts 8 × P cycles, which brings several whole frames with different prescaler values into a run of a few hundred cycles. With these short frames the bench can cover a zero prescaler, a change in the middle of a frame, both polarities, mid-run buffer writes, writes to addresses just outside the buffer, and toggling of each enable group. It compares every pin on every cycle against the expected waveform.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int NUM_COM = 4;
  localparam int COM_W   = 2;

  typedef logic [1:0] level_t;
  localparam level_t LV_VSS = 2'b00;
  localparam level_t LV_V1  = 2'b01;
  localparam level_t LV_V2  = 2'b10;
  localparam level_t LV_VCC = 2'b11;

  // strobes from the timing control to the waveform datapath
  typedef struct packed {
    logic [COM_W-1:0] comIdx;
    logic             pol;
  } ctrl_strb_t;
endpackage

// File: rtl/lcd_timing_ctrl.sv
module lcd_timing_ctrl
  import lcd_pkg::*;
#(
  parameter int FIXED_DIV   = 64,
  parameter int PHASE_TICKS = 64,
  parameter int PRE_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] prescale,
  output ctrl_strb_t       strb
);
  localparam int DIV_W = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;
  localparam int TCK_W = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(FIXED_DIV - 1);
  localparam logic [TCK_W-1:0] TCK_LAST = TCK_W'(PHASE_TICKS - 1);
  localparam logic [COM_W-1:0] COM_LAST = COM_W'(NUM_COM - 1);

  logic [DIV_W-1:0] divCnt;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLatched;
  logic [TCK_W-1:0] tickCnt;
  logic [COM_W-1:0] comIdx;
  logic             pol;

  logic divEnd, preEnd, tick, phaseEnd, frameEnd;

  always_comb begin
    divEnd   = (divCnt == DIV_LAST);
    preEnd   = (preCnt == preLatched - PRE_W'(1));
    tick     = divEnd && preEnd;
    phaseEnd = tick && (tickCnt == TCK_LAST);
    frameEnd = phaseEnd && (comIdx == COM_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt     <= '0;
      preCnt     <= '0;
      preLatched <= PRE_W'(1);
      tickCnt    <= '0;
      comIdx     <= '0;
      pol        <= 1'b0;
    end else begin
      divCnt <= divEnd ? '0 : divCnt + DIV_W'(1);
      if (divEnd) preCnt <= preEnd ? '0 : preCnt + PRE_W'(1);
      if (tick) tickCnt <= phaseEnd ? '0 : tickCnt + TCK_W'(1);
      if (phaseEnd) comIdx <= comIdx + COM_W'(1);
      if (frameEnd) begin
        pol        <= ~pol;
        preLatched <= (prescale == '0) ? PRE_W'(1) : prescale;
      end
    end
  end

  assign strb.comIdx = comIdx;
  assign strb.pol    = pol;
endmodule

// File: rtl/lcd_wave_datapath.sv
module lcd_wave_datapath
  import lcd_pkg::*;
#(
  parameter int          NUM_SEG   = 14,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  BASE_ADDR = 8'hE1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [2*NUM_COM-1:0]   wrData,
  input  ctrl_strb_t             strb,
  input  logic                   enGrpA,
  input  logic                   enGrpB,
  input  logic                   enGrpC,
  output logic [2*NUM_COM-1:0]   comLevel,
  output logic [2*NUM_SEG-1:0]   segLevel,
  output logic [NUM_COM-1:0]     comDrive,
  output logic [NUM_SEG-1:0]     segDrive
);
  localparam int NUM_BYTES = NUM_SEG / 2;
  localparam int BYTE_W    = 2 * NUM_COM;
  localparam int GRP_A_END = 4;
  localparam int GRP_B_END = 6;

  logic [BYTE_W-1:0] dispBuf [NUM_BYTES];

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_buf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dispBuf[b] <= '0;
      else if (wrEn && (wrAddr == ADDR_W'(BASE_ADDR + b))) dispBuf[b] <= wrData;
    end
  end

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    level_t lvl;
    always_comb begin
      if (strb.comIdx == COM_W'(c)) lvl = strb.pol ? LV_VSS : LV_VCC;
      else                          lvl = strb.pol ? LV_V2  : LV_V1;
    end
    assign comLevel[2*c +: 2] = enGrpA ? lvl : LV_VSS;
    assign comDrive[c]        = enGrpA;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam int LANE = (s % 2 == 0) ? NUM_COM : 0;
    logic [NUM_COM-1:0] nib;
    logic   pix;
    logic   en;
    level_t lvl;
    assign nib = dispBuf[s/2][LANE +: NUM_COM];
    assign pix = nib[strb.comIdx];
    if (s < GRP_A_END) begin : g_a
      assign en = enGrpA;
    end else if (s < GRP_B_END) begin : g_b
      assign en = enGrpB;
    end else begin : g_c
      assign en = enGrpC;
    end
    always_comb begin
      if (pix) lvl = strb.pol ? LV_VCC : LV_VSS;
      else     lvl = strb.pol ? LV_V1  : LV_V2;
    end
    assign segLevel[2*s +: 2] = en ? lvl : LV_VSS;
    assign segDrive[s]        = en;
  end
endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
  import lcd_pkg::*;
#(
  parameter int         FIXED_DIV   = 64,
  parameter int         PHASE_TICKS = 64,
  parameter int         PRE_W       = 8,
  parameter int         NUM_SEG     = 14,
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] BASE_ADDR   = 8'hE1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [7:0]           wrData,
  input  logic [PRE_W-1:0]     prescale,
  input  logic                 enGrpA,
  input  logic                 enGrpB,
  input  logic                 enGrpC,
  output logic [7:0]           comLevel,
  output logic [2*NUM_SEG-1:0] segLevel,
  output logic [3:0]           comDrive,
  output logic [NUM_SEG-1:0]   segDrive
);
  ctrl_strb_t strb;

  lcd_timing_ctrl #(
    .FIXED_DIV(FIXED_DIV), .PHASE_TICKS(PHASE_TICKS), .PRE_W(PRE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .prescale(prescale), .strb(strb)
  );

  lcd_wave_datapath #(
    .NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .enGrpA(enGrpA), .enGrpB(enGrpB), .enGrpC(enGrpC),
    .comLevel(comLevel), .segLevel(segLevel),
    .comDrive(comDrive), .segDrive(segDrive)
  );
endmodule

// File: rtl/lcd_mux_checker.sv
module lcd_mux_checker
  import lcd_pkg::*;
#(
  parameter int NUM_SEG = 14,
  parameter int PRE_W   = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 enGrpA,
  input logic                 enGrpC,
  input logic [7:0]           comLevel,
  input logic [NUM_SEG-1:0]   segDrive,
  input ctrl_strb_t           strb,
  input logic [PRE_W-1:0]     curPre
);
  logic [NUM_COM-1:0] activeMask;
  always_comb
    for (int c = 0; c < NUM_COM; c++)
      activeMask[c] = (comLevel[2*c +: 2] == LV_VSS) || (comLevel[2*c +: 2] == LV_VCC);

  // R4: exactly one common sits at a rail while the commons are driven
  p_single_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    enGrpA |-> $countones(activeMask) == 1);

  // R6: the active common only ever advances by one
  p_phase_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.comIdx != $past(strb.comIdx)) |-> (strb.comIdx == $past(strb.comIdx) + 2'd1));

  // R7: polarity changes only on the COM3 to COM0 handover
  p_pol_at_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pol != $past(strb.pol)) |-> (strb.comIdx == 2'd0 && $past(strb.comIdx) == 2'd3));

  // R9: the prescaler in use changes only at a frame boundary
  p_pre_at_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    (curPre != $past(curPre)) |-> (strb.comIdx == 2'd0 && $past(strb.comIdx) == 2'd3));

  // R8: the prescaler in use is never zero
  p_pre_nonzero_r8: assert property (@(posedge clk) disable iff (!rstN)
    curPre != '0);

  // R10: a disabled group C leaves its pins undriven
  p_grp_c_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enGrpC |-> segDrive[NUM_SEG-1:6] == '0);
endmodule

bind lcd_mux_driver lcd_mux_checker #(.NUM_SEG(NUM_SEG), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rstN(rstN), .enGrpA(enGrpA), .enGrpC(enGrpC),
  .comLevel(comLevel), .segDrive(segDrive), .strb(strb),
  .curPre(u_ctrl.preLatched)
);

// File: tb/lcd_mux_driver_bench.sv
module lcd_mux_driver_bench;
  localparam int FD = 2;
  localparam int PT = 4;
  localparam int NS = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0, wrData = '0, prescale = '0;
  logic enGrpA = 1'b1, enGrpB = 1'b1, enGrpC = 1'b1;
  logic [7:0] comLevel;
  logic [2*NS-1:0] segLevel;
  logic [3:0] comDrive;
  logic [NS-1:0] segDrive;

  int total = 0, bad = 0, cyc = 0;
  bit monDone = 0;
  logic [7:0] shadow [7];

  typedef struct { int com; int pol; int len; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  lcd_mux_driver #(.FIXED_DIV(FD), .PHASE_TICKS(PT)) u_lcd_mux_driver (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .prescale(prescale), .enGrpA(enGrpA), .enGrpB(enGrpB), .enGrpC(enGrpC),
    .comLevel(comLevel), .segLevel(segLevel), .comDrive(comDrive), .segDrive(segDrive)
  );

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // expected pin image from the requirements
  task automatic expect_pins(int a, int p, output logic [7:0] eCom,
                             output logic [2*NS-1:0] eSeg, output logic [3:0] eCd,
                             output logic [NS-1:0] eSd);
    for (int c = 0; c < 4; c++) begin
      logic [1:0] l;
      if (c == a) l = p ? 2'b00 : 2'b11;   // R4
      else        l = p ? 2'b10 : 2'b01;
      eCom[2*c +: 2] = enGrpA ? l : 2'b00;
      eCd[c] = enGrpA;
    end
    for (int s = 0; s < NS; s++) begin
      logic [1:0] l;
      logic pix, en;
      pix = (s % 2 == 0) ? shadow[s/2][4+a] : shadow[s/2][a];  // R3
      if (pix) l = p ? 2'b11 : 2'b00;      // R5
      else     l = p ? 2'b01 : 2'b10;
      en = (s < 4) ? enGrpA : (s < 6) ? enGrpB : enGrpC;
      eSeg[2*s +: 2] = en ? l : 2'b00;
      eSd[s] = en;
    end
  endtask

  task automatic push_frame(int p, int pre);
    for (int c = 0; c < 4; c++) q.push_back('{com: c, pol: p, len: FD*PT*pre});
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
    if (a >= 8'hE1 && a <= 8'hE7) shadow[a - 8'hE1] = d;   // R2
  endtask

  // monitor: pops expected phases and compares every pin each cycle
  initial begin
    logic [7:0] eCom; logic [2*NS-1:0] eSeg; logic [3:0] eCd; logic [NS-1:0] eSd;
    wait (rstN);
    while (q.size() > 0) begin
      exp_t cur;
      cur = q.pop_front();
      for (int k = 0; k < cur.len; k++) begin
        @(negedge clk);
        expect_pins(cur.com, cur.pol, eCom, eSeg, eCd, eSd);
        check("R6/R7/R4 commons", 64'(comLevel), 64'(eCom));
        check("R2/R3/R5 segments", 64'(segLevel), 64'(eSeg));
        check("R10 drive flags", 64'({comDrive, segDrive}), 64'({eCd, eSd}));
      end
    end
    monDone = 1;
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!monDone) begin
      total++; bad++;
      $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] eCom; logic [2*NS-1:0] eSeg; logic [3:0] eCd; logic [NS-1:0] eSd;
    for (int i = 0; i < 7; i++) shadow[i] = '0;
    // R8: prescale 0 at the first boundary; R9: later changes mid-frame
    push_frame(0, 1); push_frame(1, 1); push_frame(0, 3); push_frame(1, 3);
    push_frame(0, 2); push_frame(1, 5); push_frame(0, 5);
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_pins(0, 0, eCom, eSeg, eCd, eSd);
    check("R1 reset commons", 64'(comLevel), 64'(eCom));
    check("R1 reset segments", 64'(segLevel), 64'(eSeg));
    @(posedge clk); #1 rstN = 1'b1;

    wait_to(40);  prescale = 8'd3;           // R9: takes effect at cycle 64
    wr(8'hE1, 8'hA5);                         // R3 mapping patterns
    wr(8'hE4, 8'h3C);
    wr(8'hE7, 8'hF0);
    wait_to(100); enGrpB = 1'b0;              // R10
    wr(8'hE0, 8'hFF);                         // R2 out of range
    wr(8'hE8, 8'hFF);
    wr(8'hE5, 8'h81);
    wait_to(150); enGrpA = 1'b0; enGrpB = 1'b1;
    wait_to(200); prescale = 8'd2; enGrpA = 1'b1;
    wr(8'hE2, 8'h0F);
    wait_to(290); prescale = 8'd5;            // R9: mid-frame change
    wait_to(330); enGrpC = 1'b0;
    wr(8'hE3, 8'h5A);
    wr(8'hE6, 8'hC3);
    wait_to(420); enGrpC = 1'b1;
    wr(8'hE1, 8'h00);
    wait (monDone);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule